// File: doc/BRIEF.md
# NMI Flag and Clear Controller

The block gathers seven non-maskable fault sources into sticky per-source flag bits and keeps one master interrupt flag next to them. When a source flag is set and the master flag is clear, the master flag sets and a one-cycle NMI pulse goes to the processor core. While the master flag stays set, no further pulse is issued. A fault that arrives in that time is still recorded in its source flag.

Software reads the flag and shadow registers over a simple register bus. It acknowledges faults through a separate write-one-to-clear register. Both self-test error sources also keep a shadow copy, and the same clear bit resets that copy. A hardware set always wins over a software clear in the same cycle. If software clears the master flag while a source flag is still pending, a new pulse is issued, so no fault is lost whatever order the clears come in.

Register word addresses: 0 is the flag register, 1 is the shadow register, 2 is the clear register. Source bit positions in all three registers:

| Bit | Source |
|-----|--------|
| 0 | master NMI flag |
| 1 | clock failure |
| 4 | local self-test error |
| 5 | peer self-test error |
| 6 | external pin NMI |
| 7 | peer interrupt-controller error |
| 8 | peer-core watchdog reset |
| 9 | interconnect error |

The strobe input `fault_evt_i[k]` feeds sources in table order, so index 0 is clock failure and index 6 is interconnect error.

Top module: `nmi_flag_ctrl`

## Requirements
- R1: After reset, the flag register and the shadow register both read 0 and `nmi_o` is low.
- R2: A one-cycle strobe on `fault_evt_i[k]` sets the matching flag bit from the table, and a read shows it one cycle after the strobe.
- R3: When a source flag is set and the master flag (bit 0) is clear, the master flag sets in the next cycle. `nmi_o` is high for exactly that one cycle.
- R4: While the master flag is set, new faults set their source flags but `nmi_o` stays low.
- R5: Writing 1 to a clear-register bit (address 2) resets the matching flag bit. Bits written as 0 leave their flags unchanged.
- R6: The clear register always reads 0. Writes to the flag register (address 0) and the shadow register (address 1) have no effect.
- R7: Strobes on the two self-test sources also set shadow register bits 4 and 5. Clear bits 4 and 5 reset the flag bit and the shadow bit together.
- R8: If a fault strobe and a clear write hit the same source bit in the same cycle, the bit ends up set.
- R9: The master flag leaves the set state only through clear bit 0 or reset. If a source flag is still set after that clear, the master flag sets again one cycle later with a new `nmi_o` pulse. If no source flag is set, the master flag stays clear.
- R10: Bits 2, 3 and 31:10 read 0 in every register. Shadow bits other than 4 and 5 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous system reset |
| fault_evt_i | input | 7 | One-cycle fault strobes, one per source |
| addr_i | input | 2 | Register word address |
| we_i | input | 1 | Write enable |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| nmi_o | output | 1 | One-cycle NMI pulse to the core |

## Verification
The assertions assume that fault strobes and bus writes are sampled only on rising clock edges. They also assume that a write to the clear register acts in the one cycle in which `we_i` is high. The bench changes every input on the falling edge and holds each strobe and each write for exactly one cycle. This keeps the per-bit set/clear properties and the single-cycle pulse property inside those assumptions. The address is always 0 to 2 when `we_i` is high, so the inactive encoding 3 is never exercised by a write.

// File: rtl/nmi_flag_pkg.sv
package nmi_flag_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned ADDR_W  = 2;
  localparam int unsigned NUM_SRC = 7;
  localparam int unsigned MASTER_BIT = 0;

  typedef enum logic [ADDR_W-1:0] {
    REG_FLAG   = 2'd0,
    REG_SHADOW = 2'd1,
    REG_CLEAR  = 2'd2
  } reg_sel_e;

  // sources with a shadow copy (local and peer self-test)
  localparam logic [NUM_SRC-1:0] SHADOW_EN = 7'b000_0110;

  // register bit position of each source index
  function automatic int unsigned src_bit(input int unsigned idx);
    case (idx)
      0:       return 1;
      1:       return 4;
      2:       return 5;
      3:       return 6;
      4:       return 7;
      5:       return 8;
      default: return 9;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] defined_mask();
    logic [DATA_W-1:0] m;
    m = '0;
    m[MASTER_BIT] = 1'b1;
    for (int unsigned i = 0; i < NUM_SRC; i++) m[src_bit(i)] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/nmi_src_flags.sv
module nmi_src_flags #(
  parameter int unsigned           N_SRC  = 7,
  parameter logic [N_SRC-1:0]      SHD_EN = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] evt_i,
  input  logic [N_SRC-1:0] clr_i,
  output logic [N_SRC-1:0] flag_o,
  output logic [N_SRC-1:0] shadow_o
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    logic flag_q;

    // hardware set has priority over software clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q <= 1'b0;
      else         flag_q <= evt_i[i] | (flag_q & ~clr_i[i]);
    end
    assign flag_o[i] = flag_q;

    if (SHD_EN[i]) begin : g_shd
      logic shd_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) shd_q <= 1'b0;
        else         shd_q <= evt_i[i] | (shd_q & ~clr_i[i]);
      end
      assign shadow_o[i] = shd_q;

      p_shd_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i[i] && !evt_i[i] |=> !shadow_o[i]);
    end else begin : g_no_shd
      assign shadow_o[i] = 1'b0;
    end

    p_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[i] |=> flag_o[i]);
    p_clr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i[i] && !evt_i[i] |=> !flag_o[i]);
    p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flag_o[i] && !clr_i[i] |=> flag_o[i]);
    p_prio_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[i] && clr_i[i] |=> flag_o[i]);
  end
endmodule

// File: rtl/nmi_master.sv
module nmi_master (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic any_src_i,
  input  logic clr_i,
  output logic master_o,
  output logic nmi_o
);
  logic master_q, master_d, nmi_q;

  always_comb begin
    master_d = master_q;
    if (clr_i)                   master_d = 1'b0;
    if (!master_q && any_src_i)  master_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      master_q <= 1'b0;
      nmi_q    <= 1'b0;
    end else begin
      master_q <= master_d;
      nmi_q    <= master_d & ~master_q;
    end
  end

  assign master_o = master_q;
  assign nmi_o    = nmi_q;

  p_single_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_o |=> !nmi_o);
  p_pulse_master_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_o |-> master_o);
  p_raise_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_o && any_src_i |=> master_o && nmi_o);
  p_block_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    master_o && !clr_i |=> master_o && !nmi_o);
  p_clear_only_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(master_o) |-> $past(clr_i));
endmodule

// File: rtl/nmi_regif.sv
module nmi_regif
  import nmi_flag_pkg::*;
#(
  parameter int unsigned DW    = DATA_W,
  parameter int unsigned AW    = ADDR_W,
  parameter int unsigned N_SRC = NUM_SRC
) (
  input  logic [AW-1:0]    addr_i,
  input  logic             we_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [N_SRC-1:0] flag_i,
  input  logic [N_SRC-1:0] shadow_i,
  input  logic             master_i,
  output logic [N_SRC-1:0] clr_src_o,
  output logic             clr_master_o,
  output logic [DW-1:0]    rdata_o
);
  localparam logic [DW-1:0] MAP_MASK = DW'(defined_mask());

  logic          clr_wr;
  logic [DW-1:0] flag_word, shadow_word;

  assign clr_wr       = we_i && (addr_i == AW'(REG_CLEAR));
  assign clr_master_o = clr_wr & wdata_i[MASTER_BIT];

  always_comb begin
    flag_word   = '0;
    shadow_word = '0;
    flag_word[MASTER_BIT] = master_i;
    for (int unsigned i = 0; i < N_SRC; i++) begin
      flag_word[src_bit(i)]   = flag_i[i];
      shadow_word[src_bit(i)] = shadow_i[i];
    end
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_clr
    assign clr_src_o[i] = clr_wr & wdata_i[src_bit(i)];
  end

  // reserved write bits have no function
  logic unused_w;
  assign unused_w = ^(wdata_i & ~MAP_MASK);

  always_comb begin
    case (addr_i)
      AW'(REG_FLAG):   rdata_o = flag_word;
      AW'(REG_SHADOW): rdata_o = shadow_word;
      default:         rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/nmi_flag_ctrl.sv
module nmi_flag_ctrl
  import nmi_flag_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] fault_evt_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               we_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               nmi_o
);
  localparam logic [DATA_W-1:0] MAP_MASK = DATA_W'(defined_mask());

  logic [NUM_SRC-1:0] flag, shadow, clr_src;
  logic               master, clr_master;

  nmi_src_flags #(.N_SRC(NUM_SRC), .SHD_EN(SHADOW_EN)) u_src (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (fault_evt_i),
    .clr_i    (clr_src),
    .flag_o   (flag),
    .shadow_o (shadow)
  );

  nmi_master u_master (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .any_src_i (|flag),
    .clr_i     (clr_master),
    .master_o  (master),
    .nmi_o     (nmi_o)
  );

  nmi_regif #(.DW(DATA_W), .AW(ADDR_W), .N_SRC(NUM_SRC)) u_regif (
    .addr_i       (addr_i),
    .we_i         (we_i),
    .wdata_i      (wdata_i),
    .flag_i       (flag),
    .shadow_i     (shadow),
    .master_i     (master),
    .clr_src_o    (clr_src),
    .clr_master_o (clr_master),
    .rdata_o      (rdata_o)
  );

  always_comb begin
    if (rst_ni) begin
      p_rsvd_r10: assert ((rdata_o & ~MAP_MASK) == '0);
    end
  end

  p_clr_reads_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i == ADDR_W'(REG_CLEAR) |-> rdata_o == '0);
endmodule

// File: tb/nmi_flag_ctrl_tb.sv
module nmi_flag_ctrl_tb;
  localparam time CLK_P = 20ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  evt = '0;
  logic [1:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        nmi;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  nmi_flag_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .fault_evt_i(evt), .addr_i(addr),
    .we_i(we), .wdata_i(wdata), .rdata_o(rdata), .nmi_o(nmi)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  // one cycle of stimulus, starting and ending on a falling edge
  task automatic cyc(input logic [6:0] e, input logic w, input logic [1:0] a, input logic [31:0] d);
    evt = e; we = w; addr = a; wdata = d;
    @(negedge clk);
    evt = '0; we = 1'b0; wdata = '0; addr = 2'd0;
  endtask

  task automatic idle();
    cyc('0, 1'b0, 2'd0, '0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(2'd0, d); chk("R1 flag", d, 0);
    rd(2'd1, d); chk("R1 shadow", d, 0);
    chk("R1 nmi", 32'(nmi), 0);
  endtask

  task automatic t_single();
    logic [31:0] d;
    cyc(7'h01, 1'b0, 2'd0, '0);
    rd(2'd0, d); chk("R2 clock fail flag", d, 32'h2);
    chk("R2 no pulse yet", 32'(nmi), 0);
    idle();
    rd(2'd0, d); chk("R3 master set", d, 32'h3);
    chk("R3 pulse", 32'(nmi), 1);
    idle();
    chk("R3 pulse one cycle", 32'(nmi), 0);
  endtask

  task automatic t_blocked();
    logic [31:0] d;
    int pulses = 0;
    cyc(7'h08, 1'b0, 2'd0, '0);
    if (nmi) pulses++;
    for (int i = 0; i < 3; i++) begin
      idle();
      if (nmi) pulses++;
    end
    rd(2'd0, d); chk("R4 ext flag recorded", d, 32'h43);
    chk("R4 no extra pulse", 32'(pulses), 0);
  endtask

  task automatic t_clear_order();
    logic [31:0] d;
    cyc('0, 1'b1, 2'd2, 32'h42);
    rd(2'd0, d); chk("R5 sources cleared, master kept", d, 32'h1);
    cyc('0, 1'b1, 2'd2, 32'h1);
    rd(2'd0, d); chk("R9 master cleared", d, 0);
    idle();
    rd(2'd0, d); chk("R9 no re-raise without source", d, 0);
    chk("R9 no pulse", 32'(nmi), 0);
  endtask

  task automatic t_repulse();
    logic [31:0] d;
    cyc(7'h10, 1'b0, 2'd0, '0);
    idle();
    chk("R3 intc pulse", 32'(nmi), 1);
    cyc('0, 1'b1, 2'd2, 32'h1);
    rd(2'd0, d); chk("R9 master only cleared", d, 32'h80);
    idle();
    rd(2'd0, d); chk("R9 master re-set", d, 32'h81);
    chk("R9 new pulse", 32'(nmi), 1);
    cyc('0, 1'b1, 2'd2, 32'h81);
    rd(2'd0, d); chk("R5 all cleared", d, 0);
  endtask

  task automatic t_shadow();
    logic [31:0] d;
    cyc(7'h06, 1'b0, 2'd0, '0);
    rd(2'd1, d); chk("R7 shadow set", d, 32'h30);
    idle();
    rd(2'd0, d); chk("R7 flags set", d, 32'h31);
    cyc('0, 1'b1, 2'd2, 32'h10);
    rd(2'd1, d); chk("R7 shadow bit4 cleared", d, 32'h20);
    rd(2'd0, d); chk("R7 flag bit4 cleared", d, 32'h21);
    cyc('0, 1'b1, 2'd2, 32'h21);
    rd(2'd1, d); chk("R7 shadow empty", d, 0);
    rd(2'd0, d); chk("R7 flags empty", d, 0);
  endtask

  task automatic t_priority();
    logic [31:0] d;
    cyc(7'h08, 1'b0, 2'd0, '0);
    idle();
    cyc(7'h08, 1'b1, 2'd2, 32'h40);
    rd(2'd0, d); chk("R8 set wins over clear", d, 32'h41);
    cyc('0, 1'b1, 2'd2, 32'h41);
    rd(2'd0, d); chk("R8 later clear", d, 0);
  endtask

  task automatic t_readonly();
    logic [31:0] d;
    cyc(7'h20, 1'b0, 2'd0, '0);
    idle();
    cyc('0, 1'b1, 2'd0, 32'h0);
    cyc('0, 1'b1, 2'd1, 32'hFFFF_FFFF);
    rd(2'd0, d); chk("R6 flag write ignored", d, 32'h101);
    rd(2'd1, d); chk("R6 shadow write ignored", d, 0);
    rd(2'd2, d); chk("R6 clear reads 0", d, 0);
    cyc(7'h7F, 1'b0, 2'd0, '0);
    rd(2'd0, d); chk("R10 only defined flag bits", d, 32'h3F3);
    rd(2'd1, d); chk("R10 only self-test shadow bits", d, 32'h30);
    rd(2'd2, d); chk("R6 clear reads 0 with flags set", d, 0);
    cyc('0, 1'b1, 2'd2, 32'hFFFF_FFFF);
    idle();
    rd(2'd0, d); chk("R9 cleared together stays clear", d, 0);
    rd(2'd1, d); chk("R7 shadow cleared", d, 0);
    chk("R9 no pulse after full clear", 32'(nmi), 0);
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_blocked();
    t_clear_order();
    t_repulse();
    t_shadow();
    t_priority();
    t_readonly();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule